// File: doc/BRIEF.md
# Fault-Triggered Internal Reset Generator

This block watches two things a runaway or misconfigured CPU can do wrong: fetch an instruction from a region that holds only data, and write a clock-control value that would switch off the oscillator currently running the system clock. When either happens, it produces an internal reset pulse of fixed, bounded length. For the whole pulse it also pulls the external reset pad low, so that devices on the board are reset together with the core.

Illegal fetches are called address traps. A trap is raised for fetches from the register window and from the debug buffer window. Fetches from on-chip RAM raise a trap only when the RAM-trap enable is set. A mode input sends address traps to an interrupt request instead of a reset. In that mode the trapping fetch is flagged so that the core can abort it. A clock-control write that would stop the oscillator in use is vetoed, so the oscillator keeps running, and the write triggers a reset. A cause register records which kind of fault caused the last reset. It keeps its value across the generated reset and is cleared only by power-on reset or by a software clear strobe. After the reset is released, the core reads the reset vector and starts fetching there.

Top module: `fault_reset_gen`

## Requirements
- R1: A valid fetch whose address lies inside the register window [sfr_lo, sfr_hi] or the debug buffer window [dbuf_lo, dbuf_hi] (bounds inclusive) is always an address trap.
- R2: A valid fetch inside the RAM window [ram_lo, ram_hi] (bounds inclusive) is an address trap only while ram_trap_en is 1.
- R3: With trap_as_irq = 1, an address trap drives trap_irq high for exactly the one cycle after the fetch and starts no reset.
- R4: With trap_as_irq = 0, an address trap starts a reset pulse on the clock edge that samples the fetch.
- R5: A reset pulse holds int_rst and rst_pad_pull high for exactly PULSE_LEN cycles (default 24), starting the cycle after the trigger.
- R6: A trigger that arrives while a pulse is active reloads the count, so the pulse ends PULSE_LEN cycles after the last trigger.
- R7: A valid clock write that clears both hf_en and lf_en (old 1, new 0) is a clock fault.
- R8: A clock write that clears hf_en while clk_sel_lf = 0, or clears lf_en while clk_sel_lf = 1, is a clock fault. Clearing only the oscillator that is not selected is not a fault.
- R9: During a clock-fault write, ckw_veto is high in the same cycle, and the fault starts a reset regardless of trap_as_irq.
- R10: cause_addr_trap / cause_clk_fault are set in the cycle after a reset-producing trap or fault and are held through the pulse. They are cleared by cause_clr or por_n. A set in the same cycle as a clear wins.
- R11: fetch_abort is high, in the same cycle, for every valid trapping fetch in either mode.
- R12: A fetch outside all trapped windows, or any clock data presented while ckw_valid = 0, has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | AW | Fetch address |
| sfr_lo | input | AW | Register window lower bound |
| sfr_hi | input | AW | Register window upper bound |
| dbuf_lo | input | AW | Debug buffer window lower bound |
| dbuf_hi | input | AW | Debug buffer window upper bound |
| ram_lo | input | AW | RAM window lower bound |
| ram_hi | input | AW | RAM window upper bound |
| ram_trap_en | input | 1 | Treat RAM fetches as traps |
| trap_as_irq | input | 1 | 1: traps raise an interrupt; 0: traps reset |
| ckw_valid | input | 1 | Clock-control write strobe |
| hf_en_old | input | 1 | Current high-frequency oscillator enable |
| lf_en_old | input | 1 | Current low-frequency oscillator enable |
| hf_en_new | input | 1 | Written high-frequency oscillator enable |
| lf_en_new | input | 1 | Written low-frequency oscillator enable |
| clk_sel_lf | input | 1 | Current clock select (1 = low-frequency) |
| cause_clr | input | 1 | Software clear of the cause register |
| int_rst | output | 1 | Internal reset, active high |
| rst_pad_pull | output | 1 | 1 = pull the external reset pad low |
| trap_irq | output | 1 | One-cycle address-trap interrupt request |
| fetch_abort | output | 1 | The current fetch traps and must be aborted |
| ckw_veto | output | 1 | The current clock write must not apply |
| cause_addr_trap | output | 1 | Last reset came from an address trap |
| cause_clk_fault | output | 1 | Last reset came from a clock fault |

## Verification
The assertions assume that each window's lower bound does not exceed its upper bound. They also assume that the clock-control "old" inputs reflect the live register value whenever ckw_valid is high. The stimulus uses fixed, disjoint, well-ordered windows and always presents consistent old/new enable pairs. It holds each fetch or write for a single cycle and then lets any pulse drain before applying the next vector.

// File: rtl/frg_pkg.sv
package frg_pkg;

  typedef struct packed {
    logic clk_fault;
    logic addr_trap;
  } cause_t;

  // An enable is cleared when the write turns a 1 into a 0.
  function automatic logic en_cleared(input logic old_v, input logic new_v);
    return old_v & ~new_v;
  endfunction

  // A write kills the running clock when both oscillators stop, or when the
  // selected oscillator stops (sel_lf = 0 -> high-frequency source).
  function automatic logic kills_clock(input logic hf_old, input logic lf_old,
                                       input logic hf_new, input logic lf_new,
                                       input logic sel_lf);
    logic hf_c, lf_c;
    hf_c = en_cleared(hf_old, hf_new);
    lf_c = en_cleared(lf_old, lf_new);
    return (hf_c & lf_c) | (hf_c & ~sel_lf) | (lf_c & sel_lf);
  endfunction

endpackage

// File: rtl/frg_fetch_trap.sv
module frg_fetch_trap #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:0] sfr_lo,
  input  logic [AW-1:0] sfr_hi,
  input  logic [AW-1:0] dbuf_lo,
  input  logic [AW-1:0] dbuf_hi,
  input  logic [AW-1:0] ram_lo,
  input  logic [AW-1:0] ram_hi,
  input  logic          ram_trap_en,
  input  logic          trap_as_irq,
  output logic          trap_hit,
  output logic          trap_rst_evt,
  output logic          trap_irq_evt
);

  localparam int NREG = 3;
  localparam int RG_SFR = 0;
  localparam int RG_DBUF = 1;
  localparam int RG_RAM = 2;

  logic [NREG-1:0][AW-1:0] lo_v, hi_v;
  logic [NREG-1:0]         in_win;
  logic [NREG-1:0]         armed;

  function automatic logic in_window(input logic [AW-1:0] a,
                                     input logic [AW-1:0] lo,
                                     input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  assign lo_v[RG_SFR]  = sfr_lo;
  assign hi_v[RG_SFR]  = sfr_hi;
  assign lo_v[RG_DBUF] = dbuf_lo;
  assign hi_v[RG_DBUF] = dbuf_hi;
  assign lo_v[RG_RAM]  = ram_lo;
  assign hi_v[RG_RAM]  = ram_hi;

  for (genvar g = 0; g < NREG; g++) begin : g_win
    assign in_win[g] = in_window(fetch_addr, lo_v[g], hi_v[g]);
    if (g == RG_RAM) begin : g_gated
      assign armed[g] = ram_trap_en;
    end else begin : g_fixed
      assign armed[g] = 1'b1;
    end
  end

  assign trap_hit     = fetch_valid & |(in_win & armed);
  assign trap_rst_evt = trap_hit & ~trap_as_irq;
  assign trap_irq_evt = trap_hit & trap_as_irq;

  // RAM-only fetch with the enable off never traps.
  p_ram_gate_r2: assert property (@(posedge clk) disable iff (!por_n)
    (fetch_valid && in_win[RG_RAM] && !in_win[RG_SFR] && !in_win[RG_DBUF] && !ram_trap_en)
      |-> !trap_hit);

  // Register and debug buffer windows always trap.
  p_fixed_trap_r1: assert property (@(posedge clk) disable iff (!por_n)
    (fetch_valid && (in_win[RG_SFR] || in_win[RG_DBUF])) |-> trap_hit);

  // Mode chooses exactly one outcome.
  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!por_n)
    !(trap_rst_evt && trap_irq_evt));

endmodule

// File: rtl/frg_clk_guard.sv
module frg_clk_guard
  import frg_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic ckw_valid,
  input  logic hf_en_old,
  input  logic lf_en_old,
  input  logic hf_en_new,
  input  logic lf_en_new,
  input  logic clk_sel_lf,
  output logic clk_fault_evt
);

  assign clk_fault_evt = ckw_valid &
    kills_clock(hf_en_old, lf_en_old, hf_en_new, lf_en_new, clk_sel_lf);

  // Stopping only the idle oscillator is harmless.
  p_idle_hf_off_r8: assert property (@(posedge clk) disable iff (!por_n)
    (clk_sel_lf && lf_en_old && lf_en_new) |-> !clk_fault_evt);

  p_idle_lf_off_r8: assert property (@(posedge clk) disable iff (!por_n)
    (!clk_sel_lf && hf_en_old && hf_en_new) |-> !clk_fault_evt);

  // Both oscillators stopped at once is always a fault.
  p_both_off_r7: assert property (@(posedge clk) disable iff (!por_n)
    (ckw_valid && hf_en_old && lf_en_old && !hf_en_new && !lf_en_new) |-> clk_fault_evt);

  p_no_write_r12: assert property (@(posedge clk) disable iff (!por_n)
    !ckw_valid |-> !clk_fault_evt);

endmodule

// File: rtl/frg_pulse_timer.sv
module frg_pulse_timer #(
  parameter int PULSE_LEN = 24
) (
  input  logic clk,
  input  logic por_n,
  input  logic trig,
  output logic busy
);

  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] next_count(input logic t, input logic [CW-1:0] c);
    if (t)          return LOAD;
    else if (c != '0) return c - 1'b1;
    else            return '0;
  endfunction

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cnt_q <= '0;
    else        cnt_q <= next_count(trig, cnt_q);
  end

  assign busy = (cnt_q != '0);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!por_n)
    cnt_q <= LOAD);

  p_reload_r6: assert property (@(posedge clk) disable iff (!por_n)
    trig |=> (cnt_q == LOAD));

  p_count_down_r5: assert property (@(posedge clk) disable iff (!por_n)
    (!trig && busy) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_idle_stays_r5: assert property (@(posedge clk) disable iff (!por_n)
    (!trig && !busy) |=> !busy);

endmodule

// File: rtl/fault_reset_gen.sv
module fault_reset_gen
  import frg_pkg::*;
#(
  parameter int AW        = 16,
  parameter int PULSE_LEN = 24
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:0] sfr_lo,
  input  logic [AW-1:0] sfr_hi,
  input  logic [AW-1:0] dbuf_lo,
  input  logic [AW-1:0] dbuf_hi,
  input  logic [AW-1:0] ram_lo,
  input  logic [AW-1:0] ram_hi,
  input  logic          ram_trap_en,
  input  logic          trap_as_irq,
  input  logic          ckw_valid,
  input  logic          hf_en_old,
  input  logic          lf_en_old,
  input  logic          hf_en_new,
  input  logic          lf_en_new,
  input  logic          clk_sel_lf,
  input  logic          cause_clr,
  output logic          int_rst,
  output logic          rst_pad_pull,
  output logic          trap_irq,
  output logic          fetch_abort,
  output logic          ckw_veto,
  output logic          cause_addr_trap,
  output logic          cause_clk_fault
);

  logic   trap_hit, trap_rst_evt, trap_irq_evt;
  logic   clk_fault_evt, any_trig, busy;
  logic   irq_q;
  cause_t cause_q, cause_set;

  frg_fetch_trap #(.AW(AW)) u_trap (
    .clk(clk), .por_n(por_n),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .sfr_lo(sfr_lo), .sfr_hi(sfr_hi),
    .dbuf_lo(dbuf_lo), .dbuf_hi(dbuf_hi),
    .ram_lo(ram_lo), .ram_hi(ram_hi),
    .ram_trap_en(ram_trap_en), .trap_as_irq(trap_as_irq),
    .trap_hit(trap_hit), .trap_rst_evt(trap_rst_evt), .trap_irq_evt(trap_irq_evt)
  );

  frg_clk_guard u_guard (
    .clk(clk), .por_n(por_n),
    .ckw_valid(ckw_valid),
    .hf_en_old(hf_en_old), .lf_en_old(lf_en_old),
    .hf_en_new(hf_en_new), .lf_en_new(lf_en_new),
    .clk_sel_lf(clk_sel_lf),
    .clk_fault_evt(clk_fault_evt)
  );

  assign any_trig = trap_rst_evt | clk_fault_evt;

  frg_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_timer (
    .clk(clk), .por_n(por_n), .trig(any_trig), .busy(busy)
  );

  assign cause_set.addr_trap = trap_rst_evt;
  assign cause_set.clk_fault = clk_fault_evt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      irq_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      irq_q <= trap_irq_evt;
      if (any_trig)       cause_q <= cause_set;
      else if (cause_clr) cause_q <= '0;
    end
  end

  assign int_rst         = busy;
  assign rst_pad_pull    = busy;
  assign trap_irq        = irq_q;
  assign fetch_abort     = trap_hit;
  assign ckw_veto        = clk_fault_evt;
  assign cause_addr_trap = cause_q.addr_trap;
  assign cause_clk_fault = cause_q.clk_fault;

  p_irq_source_r3: assert property (@(posedge clk) disable iff (!por_n)
    trap_irq |-> $past(fetch_valid && trap_as_irq && fetch_abort));

  p_trig_resets_r4: assert property (@(posedge clk) disable iff (!por_n)
    any_trig |=> int_rst);

  p_fault_veto_r9: assert property (@(posedge clk) disable iff (!por_n)
    clk_fault_evt |-> (ckw_valid && ckw_veto));

  p_cause_set_r10: assert property (@(posedge clk) disable iff (!por_n)
    clk_fault_evt |=> cause_clk_fault);

  p_cause_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
    (!any_trig && !cause_clr) |=> $stable(cause_q));

  p_abort_r11: assert property (@(posedge clk) disable iff (!por_n)
    fetch_abort |-> fetch_valid);

endmodule

// File: tb/fault_reset_gen_bench.sv
module fault_reset_gen_bench;

  localparam int AW = 16;
  localparam int PL = 24;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic fetch_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic [AW-1:0] sfr_lo = 16'h0000, sfr_hi = 16'h003F;
  logic [AW-1:0] dbuf_lo = 16'h0F80, dbuf_hi = 16'h0FFF;
  logic [AW-1:0] ram_lo = 16'h0040, ram_hi = 16'h043F;
  logic ram_trap_en = 1'b0, trap_as_irq = 1'b0;
  logic ckw_valid = 1'b0, hf_en_old = 1'b0, lf_en_old = 1'b0;
  logic hf_en_new = 1'b0, lf_en_new = 1'b0, clk_sel_lf = 1'b0, cause_clr = 1'b0;
  logic int_rst, rst_pad_pull, trap_irq, fetch_abort, ckw_veto;
  logic cause_addr_trap, cause_clk_fault;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fault_reset_gen #(.AW(AW), .PULSE_LEN(PL)) u_fault_reset_gen (
    .clk(clk), .por_n(por_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .sfr_lo(sfr_lo), .sfr_hi(sfr_hi), .dbuf_lo(dbuf_lo), .dbuf_hi(dbuf_hi),
    .ram_lo(ram_lo), .ram_hi(ram_hi), .ram_trap_en(ram_trap_en),
    .trap_as_irq(trap_as_irq), .ckw_valid(ckw_valid), .hf_en_old(hf_en_old),
    .lf_en_old(lf_en_old), .hf_en_new(hf_en_new), .lf_en_new(lf_en_new),
    .clk_sel_lf(clk_sel_lf), .cause_clr(cause_clr), .int_rst(int_rst),
    .rst_pad_pull(rst_pad_pull), .trap_irq(trap_irq), .fetch_abort(fetch_abort),
    .ckw_veto(ckw_veto), .cause_addr_trap(cause_addr_trap),
    .cause_clk_fault(cause_clk_fault)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic fv, ram_en, irq_mode, cv, hfo, lfo, hfn, lfn, sel;
    logic e_abort, e_veto, e_rst, e_irq;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{16'h0010, 1,0,0, 0,0,0,0,0,0, 1,0,1,0, 4'd1},  // R1 register window, reset mode
    '{16'h0FA0, 1,0,1, 0,0,0,0,0,0, 1,0,0,1, 4'd3},  // R3 debug window, irq mode
    '{16'h0100, 1,0,0, 0,0,0,0,0,0, 0,0,0,0, 4'd2},  // R2 RAM, enable off
    '{16'h0100, 1,1,0, 0,0,0,0,0,0, 1,0,1,0, 4'd2},  // R2 RAM, enable on
    '{16'h043F, 1,1,1, 0,0,0,0,0,0, 1,0,0,1, 4'd2},  // R2 RAM upper bound, irq
    '{16'h8000, 1,1,0, 0,0,0,0,0,0, 0,0,0,0, 4'd12}, // R12 program space
    '{16'h0440, 1,1,0, 0,0,0,0,0,0, 0,0,0,0, 4'd12}, // R12 just above RAM
    '{16'h0000, 0,0,0, 1,1,1,0,0,0, 0,1,1,0, 4'd7},  // R7 both cleared
    '{16'h0000, 0,0,0, 1,1,1,0,1,0, 0,1,1,0, 4'd8},  // R8 hf cleared, hf selected
    '{16'h0000, 0,0,0, 1,1,1,1,0,0, 0,0,0,0, 4'd8},  // R8 lf cleared, hf selected
    '{16'h0000, 0,0,0, 1,1,1,1,0,1, 0,1,1,0, 4'd8},  // R8 lf cleared, lf selected
    '{16'h0000, 0,0,0, 1,1,1,0,1,1, 0,0,0,0, 4'd8},  // R8 hf cleared, lf selected
    '{16'h0000, 0,0,0, 0,1,1,0,0,0, 0,0,0,0, 4'd12}, // R12 no strobe
    '{16'h0000, 0,0,0, 1,0,1,1,1,0, 0,0,0,0, 4'd8},  // R8 enabling write
    '{16'h0000, 0,0,1, 1,1,1,0,0,0, 0,1,1,0, 4'd9}   // R9 fault ignores irq mode
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fetch_valid = 0; ckw_valid = 0; hf_en_old = 0; lf_en_old = 0;
    hf_en_new = 0; lf_en_new = 0; clk_sel_lf = 0; cause_clr = 0;
  endtask

  task automatic drain();
    repeat (PL + 2) @(negedge clk);
    cause_clr = 1;
    @(negedge clk);
    cause_clr = 0;
  endtask

  task automatic fire_sfr();
    @(negedge clk);
    trap_as_irq = 0; fetch_addr = 16'h0020; fetch_valid = 1;
    @(negedge clk);
    fetch_valid = 0;
    #1;
  endtask

  task automatic clk_fault_write();
    @(negedge clk);
    ckw_valid = 1; hf_en_old = 1; lf_en_old = 1; hf_en_new = 0; lf_en_new = 0; clk_sel_lf = 0;
    @(negedge clk);
    idle_inputs();
    #1;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // reset state (R5, R10)
    check("R5 int_rst in reset", int_rst, 0);
    check("R5 pad in reset", rst_pad_pull, 0);
    check("R3 irq in reset", trap_irq, 0);
    check("R10 cause in reset", {cause_clk_fault, cause_addr_trap}, 0);
    por_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fetch_addr = VECS[i].addr; fetch_valid = VECS[i].fv;
      ram_trap_en = VECS[i].ram_en; trap_as_irq = VECS[i].irq_mode;
      ckw_valid = VECS[i].cv; hf_en_old = VECS[i].hfo; lf_en_old = VECS[i].lfo;
      hf_en_new = VECS[i].hfn; lf_en_new = VECS[i].lfn; clk_sel_lf = VECS[i].sel;
      #1;
      check($sformatf("R%0d/R11 abort vec %0d", VECS[i].req, i), fetch_abort, VECS[i].e_abort);
      check($sformatf("R%0d/R9 veto vec %0d", VECS[i].req, i), ckw_veto, VECS[i].e_veto);
      @(negedge clk);
      idle_inputs();
      #1;
      check($sformatf("R%0d/R4 int_rst vec %0d", VECS[i].req, i), int_rst, VECS[i].e_rst);
      check($sformatf("R%0d/R3 trap_irq vec %0d", VECS[i].req, i), trap_irq, VECS[i].e_irq);
      check($sformatf("R%0d pad vec %0d", VECS[i].req, i), rst_pad_pull, VECS[i].e_rst);
      @(negedge clk); #1;
      check($sformatf("R3 irq single cycle vec %0d", i), trap_irq, 0);
      drain();
    end

    // R5 pulse length
    fire_sfr();
    n = 0;
    while (int_rst && n < 100) begin
      if (!rst_pad_pull) check("R5 pad follows reset", 0, 1);
      n++;
      @(negedge clk); #1;
    end
    check("R5 pulse length", n, PL);
    drain();

    // R6 retrigger mid-pulse
    fire_sfr();
    n = 0;
    while (int_rst && n < 100) begin
      n++;
      if (n == 10) fetch_valid = 1;
      @(negedge clk);
      fetch_valid = 0;
      #1;
    end
    check("R6 retriggered length", n, PL + 10);
    drain();

    // R10 cause recording and persistence
    clk_fault_write();
    check("R10 cause after clock fault", {cause_clk_fault, cause_addr_trap}, 2);
    repeat (PL + 2) @(negedge clk);
    #1;
    check("R10 cause held after pulse", {cause_clk_fault, cause_addr_trap}, 2);
    fire_sfr();
    check("R10 cause after trap", {cause_clk_fault, cause_addr_trap}, 1);
    repeat (PL + 2) @(negedge clk);
    @(negedge clk);
    cause_clr = 1;
    @(negedge clk);
    cause_clr = 0;
    #1;
    check("R10 cause cleared by software", {cause_clk_fault, cause_addr_trap}, 0);

    // R10 irq-mode trap leaves cause alone; set wins over clear
    @(negedge clk);
    trap_as_irq = 1; fetch_addr = 16'h0005; fetch_valid = 1;
    @(negedge clk);
    fetch_valid = 0; trap_as_irq = 0;
    #1;
    check("R10 irq trap no cause", {cause_clk_fault, cause_addr_trap}, 0);
    @(negedge clk);
    ckw_valid = 1; hf_en_old = 1; lf_en_old = 1; lf_en_new = 1; hf_en_new = 0;
    cause_clr = 1;
    @(negedge clk);
    idle_inputs();
    #1;
    check("R10 set wins over clear", {cause_clk_fault, cause_addr_trap}, 2);

    // R10 power-on clears cause
    @(negedge clk);
    por_n = 0;
    #1;
    check("R10 cause cleared by por", {cause_clk_fault, cause_addr_trap}, 0);
    check("R5 reset dropped by por", int_rst, 0);
    @(negedge clk);
    por_n = 1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule